// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the status register of a small 8-bit processor core. On each cycle where the ALU signals a result, it captures carry, auxiliary carry, zero and overflow. For logical operations only the zero flag is refreshed. Two further flags record the core's power state. One marks that a halt has put the core into power-down. The other marks that the watchdog timer expired. Only dedicated instruction strobes, the watchdog event and power-on reset can change these two flags.

Software can overwrite the four arithmetic flags through a register write port. Writes never reach the power-down and time-out flags. Every flag is available as its own output and also packed into a readable status byte. Interrupt entry and subroutine calls do not touch the register, so any saving or restoring of the flags is left to software.

Top module: `cpu_status_reg`

## Requirements
- R1: On a cycle with `alu_upd_i` high and no write, the zero flag becomes 1 if `alu_res_i` is all zeros and 0 otherwise, for both arithmetic and logical operations.
- R2: On an arithmetic update (`alu_upd_i` and `alu_arith_i` high, no write), the overflow flag becomes the exclusive OR of `alu_cmsb_i` (carry into the MSB) and `alu_cout_i` (carry out of the MSB).
- R3: On an arithmetic update, carry takes `alu_cout_i` and auxiliary carry takes `alu_acy_i`. On a logical update (`alu_arith_i` low), carry, auxiliary carry and overflow keep their values.
- R4: With `alu_upd_i`, `wr_en_i`, `wdt_clr_i`, `halt_i` and `wdt_to_i` all low, no flag changes, whatever values the ALU data inputs carry.
- R5: `halt_i` sets the power-down flag and `wdt_clr_i` clears it. If both are high in the same cycle, the flag is set.
- R6: `wdt_to_i` sets the time-out flag. `wdt_clr_i` or `halt_i` clears it. If a time-out arrives in the same cycle as either clear, the flag is set.
- R7: A write with `wr_en_i` loads `wr_data_i[3:0]` into carry, auxiliary carry, zero and overflow (bits 0 to 3). A write takes priority over an ALU update in the same cycle. Write data bits 4 to 7 are ignored, so the power-down and time-out flags are unaffected.
- R8: `status_o` packs the flags as follows: bit 0 carry, bit 1 auxiliary carry, bit 2 zero, bit 3 overflow, bit 4 power-down, bit 5 time-out. Bits 6 and 7 always read 0.
- R9: An active-low `rst_ni` clears every flag asynchronously, without waiting for a clock edge.
- R10: Each change caused by a strobe or a write shows at the outputs right after the first rising clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| alu_upd_i | input | 1 | ALU result valid this cycle |
| alu_arith_i | input | 1 | 1 = arithmetic operation, 0 = logical operation |
| alu_res_i | input | 8 | ALU result |
| alu_cmsb_i | input | 1 | Carry into the result MSB |
| alu_cout_i | input | 1 | Carry out of the result MSB |
| alu_acy_i | input | 1 | Carry out of the low nibble |
| wdt_clr_i | input | 1 | Watchdog-clear instruction strobe |
| halt_i | input | 1 | Halt instruction strobe |
| wdt_to_i | input | 1 | Watchdog time-out pulse |
| wr_en_i | input | 1 | Status register write strobe |
| wr_data_i | input | 8 | Status register write data |
| c_o | output | 1 | Carry flag |
| ac_o | output | 1 | Auxiliary carry flag |
| z_o | output | 1 | Zero flag |
| ov_o | output | 1 | Overflow flag |
| pd_o | output | 1 | Power-down flag |
| to_o | output | 1 | Watchdog time-out flag |
| status_o | output | 8 | Packed status byte |

## Verification
Every flag sits one register away from its inputs. A strobe or write driven between clock edges therefore shows at the outputs right after the next rising edge, and it holds until the next strobe. The bench drives each stimulus on a falling edge and reads the outputs on the following falling edge, so every check falls in the first cycle where the new value is due. It then clears the strobes before the next vector, which also exercises the hold behaviour. The reset check is the one exception. It samples a nanosecond after `rst_ni` falls, with no clock edge in between, which confirms that the reset is asynchronous.

// File: rtl/status_pkg.sv
package status_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned STAT_W = 8;
  localparam int unsigned FLAG_N = 6;
  localparam int unsigned ARITH_N = 4;

  localparam int unsigned B_C  = 0;
  localparam int unsigned B_AC = 1;
  localparam int unsigned B_Z  = 2;
  localparam int unsigned B_OV = 3;
  localparam int unsigned B_PD = 4;
  localparam int unsigned B_TO = 5;

  // member order gives c at bit 0 when cast to a vector
  typedef struct packed {
    logic to;
    logic pd;
    logic ov;
    logic z;
    logic ac;
    logic c;
  } flags_t;
endpackage

// File: rtl/arith_flags.sv
module arith_flags
  import status_pkg::*;
#(
  parameter int unsigned RES_W = DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               upd_i,
  input  logic               arith_i,
  input  logic [RES_W-1:0]   res_i,
  input  logic               cmsb_i,
  input  logic               cout_i,
  input  logic               acy_i,
  input  logic               wr_en_i,
  input  logic [ARITH_N-1:0] wr_flags_i,
  output logic               c_o,
  output logic               ac_o,
  output logic               z_o,
  output logic               ov_o
);
  logic c_q, ac_q, z_q, ov_q;
  logic c_d, ac_d, z_d, ov_d;
  logic res_zero;

  assign res_zero = ~|res_i;

  always_comb begin
    c_d  = c_q;
    ac_d = ac_q;
    z_d  = z_q;
    ov_d = ov_q;
    if (wr_en_i) begin
      c_d  = wr_flags_i[B_C];
      ac_d = wr_flags_i[B_AC];
      z_d  = wr_flags_i[B_Z];
      ov_d = wr_flags_i[B_OV];
    end else if (upd_i) begin
      z_d = res_zero;
      if (arith_i) begin
        c_d  = cout_i;
        ac_d = acy_i;
        ov_d = cmsb_i ^ cout_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_q  <= 1'b0;
      ac_q <= 1'b0;
      z_q  <= 1'b0;
      ov_q <= 1'b0;
    end else begin
      c_q  <= c_d;
      ac_q <= ac_d;
      z_q  <= z_d;
      ov_q <= ov_d;
    end
  end

  assign c_o  = c_q;
  assign ac_o = ac_q;
  assign z_o  = z_q;
  assign ov_o = ov_q;
endmodule

// File: rtl/power_flags.sv
module power_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wdt_clr_i,
  input  logic halt_i,
  input  logic wdt_to_i,
  output logic pd_o,
  output logic to_o
);
  logic pd_q, to_q;

  // set terms dominate clear terms
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_q <= 1'b0;
      to_q <= 1'b0;
    end else begin
      if (halt_i)         pd_q <= 1'b1;
      else if (wdt_clr_i) pd_q <= 1'b0;

      if (wdt_to_i)                 to_q <= 1'b1;
      else if (wdt_clr_i || halt_i) to_q <= 1'b0;
    end
  end

  assign pd_o = pd_q;
  assign to_o = to_q;
endmodule

// File: rtl/status_pack.sv
module status_pack
  import status_pkg::*;
#(
  parameter int unsigned OUT_W = STAT_W
) (
  input  flags_t           flags_i,
  output logic [OUT_W-1:0] byte_o
);
  localparam int unsigned PAD_W = OUT_W - FLAG_N;

  generate
    if (PAD_W > 0) begin : g_pad
      assign byte_o = {{PAD_W{1'b0}}, flags_i};
    end else begin : g_nopad
      assign byte_o = flags_i;
    end
  endgenerate
endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
  import status_pkg::*;
#(
  parameter int unsigned RES_W = DATA_W,
  parameter int unsigned OUT_W = STAT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alu_upd_i,
  input  logic             alu_arith_i,
  input  logic [RES_W-1:0] alu_res_i,
  input  logic             alu_cmsb_i,
  input  logic             alu_cout_i,
  input  logic             alu_acy_i,
  input  logic             wdt_clr_i,
  input  logic             halt_i,
  input  logic             wdt_to_i,
  input  logic             wr_en_i,
  input  logic [OUT_W-1:0] wr_data_i,
  output logic             c_o,
  output logic             ac_o,
  output logic             z_o,
  output logic             ov_o,
  output logic             pd_o,
  output logic             to_o,
  output logic [OUT_W-1:0] status_o
);
  flags_t flags;
  logic   c_w, ac_w, z_w, ov_w, pd_w, to_w;

  arith_flags #(.RES_W(RES_W)) u_arith (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_i      (alu_upd_i),
    .arith_i    (alu_arith_i),
    .res_i      (alu_res_i),
    .cmsb_i     (alu_cmsb_i),
    .cout_i     (alu_cout_i),
    .acy_i      (alu_acy_i),
    .wr_en_i    (wr_en_i),
    .wr_flags_i (wr_data_i[ARITH_N-1:0]),
    .c_o        (c_w),
    .ac_o       (ac_w),
    .z_o        (z_w),
    .ov_o       (ov_w)
  );

  power_flags u_power (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wdt_clr_i (wdt_clr_i),
    .halt_i    (halt_i),
    .wdt_to_i  (wdt_to_i),
    .pd_o      (pd_w),
    .to_o      (to_w)
  );

  always_comb begin
    flags.c  = c_w;
    flags.ac = ac_w;
    flags.z  = z_w;
    flags.ov = ov_w;
    flags.pd = pd_w;
    flags.to = to_w;
  end

  status_pack #(.OUT_W(OUT_W)) u_pack (
    .flags_i (flags),
    .byte_o  (status_o)
  );

  assign c_o  = c_w;
  assign ac_o = ac_w;
  assign z_o  = z_w;
  assign ov_o = ov_w;
  assign pd_o = pd_w;
  assign to_o = to_w;

  // wr_data_i upper bits are intentionally unused (R7)
  logic unused_wr;
  assign unused_wr = ^wr_data_i[OUT_W-1:ARITH_N];
endmodule

// File: rtl/cpu_status_chk.sv
module cpu_status_chk #(
  parameter int unsigned RES_W = 8,
  parameter int unsigned OUT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             alu_upd_i,
  input logic             alu_arith_i,
  input logic [RES_W-1:0] alu_res_i,
  input logic             alu_cmsb_i,
  input logic             alu_cout_i,
  input logic             wdt_clr_i,
  input logic             halt_i,
  input logic             wdt_to_i,
  input logic             wr_en_i,
  input logic             z_o,
  input logic             ov_o,
  input logic             c_o,
  input logic             ac_o,
  input logic             pd_o,
  input logic             to_o,
  input logic [OUT_W-1:0] status_o
);
  assert_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_upd_i && !wr_en_i) |=> (z_o == ($past(alu_res_i) == '0)));

  assert_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_upd_i && alu_arith_i && !wr_en_i) |=> (ov_o == ($past(alu_cmsb_i) ^ $past(alu_cout_i))));

  assert_logic_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_upd_i && !alu_arith_i && !wr_en_i) |=> ($stable(ov_o) && $stable(c_o) && $stable(ac_o)));

  assert_idle_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alu_upd_i && !wr_en_i && !wdt_clr_i && !halt_i && !wdt_to_i) |=> $stable(status_o));

  assert_halt_sets_pd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> pd_o);

  assert_clr_clears_pd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_clr_i && !halt_i) |=> !pd_o);

  assert_timeout_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_to_i |=> to_o);

  assert_timeout_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wdt_clr_i || halt_i) && !wdt_to_i) |=> !to_o);

  assert_write_no_power_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wdt_clr_i && !halt_i && !wdt_to_i) |=> ($stable(pd_o) && $stable(to_o)));

  always @(negedge clk_i) begin
    if (rst_ni) begin
      assert_pad_zero_R8: assert (status_o[OUT_W-1:6] == '0);
      assert_layout_R8: assert (status_o[5:0] == {to_o, pd_o, ov_o, z_o, ac_o, c_o});
    end
  end
endmodule

bind cpu_status_reg cpu_status_chk #(.RES_W(RES_W), .OUT_W(OUT_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .alu_upd_i   (alu_upd_i),
  .alu_arith_i (alu_arith_i),
  .alu_res_i   (alu_res_i),
  .alu_cmsb_i  (alu_cmsb_i),
  .alu_cout_i  (alu_cout_i),
  .wdt_clr_i   (wdt_clr_i),
  .halt_i      (halt_i),
  .wdt_to_i    (wdt_to_i),
  .wr_en_i     (wr_en_i),
  .z_o         (z_o),
  .ov_o        (ov_o),
  .c_o         (c_o),
  .ac_o        (ac_o),
  .pd_o        (pd_o),
  .to_o        (to_o),
  .status_o    (status_o)
);

// File: tb/cpu_status_reg_tb_top.sv
`timescale 1ns/1ps
module cpu_status_reg_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       alu_upd_i = 1'b0, alu_arith_i = 1'b0;
  logic [7:0] alu_res_i = 8'h00;
  logic       alu_cmsb_i = 1'b0, alu_cout_i = 1'b0, alu_acy_i = 1'b0;
  logic       wdt_clr_i = 1'b0, halt_i = 1'b0, wdt_to_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic       c_o, ac_o, z_o, ov_o, pd_o, to_o;
  logic [7:0] status_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  cpu_status_reg dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .alu_upd_i(alu_upd_i), .alu_arith_i(alu_arith_i), .alu_res_i(alu_res_i),
    .alu_cmsb_i(alu_cmsb_i), .alu_cout_i(alu_cout_i), .alu_acy_i(alu_acy_i),
    .wdt_clr_i(wdt_clr_i), .halt_i(halt_i), .wdt_to_i(wdt_to_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .c_o(c_o), .ac_o(ac_o), .z_o(z_o), .ov_o(ov_o), .pd_o(pd_o), .to_o(to_o),
    .status_o(status_o)
  );

  typedef struct packed {
    logic [3:0] req;
    logic       upd;
    logic       arith;
    logic [7:0] res;
    logic       cmsb;
    logic       cout;
    logic       acy;
    logic       clr;
    logic       halt;
    logic       wto;
    logic       wr;
    logic [7:0] wdata;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 14;
  //  req upd ar  res    cm co ac cl ha to wr wdata  exp
  localparam vec_t VECS [NV] = '{
    '{4'd1, 1,1, 8'h00, 1,1,0, 0,0,0, 0, 8'h00, 8'h05}, // R1 zero, R3 carry
    '{4'd2, 1,1, 8'h80, 1,0,1, 0,0,0, 0, 8'h00, 8'h0A}, // R2 overflow, R3 aux
    '{4'd3, 1,0, 8'h00, 1,1,0, 0,0,0, 0, 8'h00, 8'h0E}, // R3 logical keeps c/ac/ov
    '{4'd4, 0,1, 8'h00, 0,1,1, 0,0,0, 0, 8'h00, 8'h0E}, // R4 no strobe
    '{4'd5, 0,0, 8'h00, 0,0,0, 0,1,0, 0, 8'h00, 8'h1E}, // R5 halt sets pd
    '{4'd6, 0,0, 8'h00, 0,0,0, 0,0,1, 0, 8'h00, 8'h3E}, // R6 timeout sets
    '{4'd5, 0,0, 8'h00, 0,0,0, 1,0,0, 0, 8'h00, 8'h0E}, // R5/R6 clear
    '{4'd6, 0,0, 8'h00, 0,0,0, 1,0,1, 0, 8'h00, 8'h2E}, // R6 timeout beats clear
    '{4'd6, 0,0, 8'h00, 0,0,0, 0,1,0, 0, 8'h00, 8'h1E}, // R6 halt clears to
    '{4'd7, 0,0, 8'h00, 0,0,0, 0,0,0, 1, 8'hFF, 8'h1F}, // R7/R8 write, pad zero
    '{4'd7, 0,0, 8'h00, 0,0,0, 0,0,0, 1, 8'h30, 8'h10}, // R7 upper bits ignored
    '{4'd7, 1,1, 8'h00, 0,0,1, 0,0,0, 1, 8'h01, 8'h11}, // R7 write beats ALU
    '{4'd6, 0,0, 8'h00, 0,0,0, 0,1,1, 0, 8'h00, 8'h31}, // R6 timeout beats halt
    '{4'd2, 1,1, 8'h7F, 0,1,0, 0,0,0, 0, 8'h00, 8'h39}  // R2 cout-only overflow, R1 nonzero
  };

  task automatic idle();
    alu_upd_i = 0; alu_arith_i = 0; alu_res_i = 8'h00;
    alu_cmsb_i = 0; alu_cout_i = 0; alu_acy_i = 0;
    wdt_clr_i = 0; halt_i = 0; wdt_to_i = 0; wr_en_i = 0; wr_data_i = 8'h00;
  endtask

  task automatic check(input logic [7:0] exp, input string tag);
    checks++;
    if (status_o !== exp) begin
      failures++;
      $display("FAIL %s status actual=%02h expected=%02h", tag, status_o, exp);
    end
    checks++;
    if ({2'b00, to_o, pd_o, ov_o, z_o, ac_o, c_o} !== exp) begin
      failures++;
      $display("FAIL %s R8 flag pins actual=%02h expected=%02h", tag,
               {2'b00, to_o, pd_o, ov_o, z_o, ac_o, c_o}, exp);
    end
  endtask

  // R10: drive on a falling edge, check on the next one
  task automatic apply(input vec_t v, input string tag);
    @(negedge clk_i);
    alu_upd_i = v.upd; alu_arith_i = v.arith; alu_res_i = v.res;
    alu_cmsb_i = v.cmsb; alu_cout_i = v.cout; alu_acy_i = v.acy;
    wdt_clr_i = v.clr; halt_i = v.halt; wdt_to_i = v.wto;
    wr_en_i = v.wr; wr_data_i = v.wdata;
    @(negedge clk_i);
    check(v.exp, tag);
    idle();
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk_i);
    check(8'h00, "R9 reset");
    rst_ni = 1;
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i], $sformatf("R%0d vec%0d R10", VECS[i].req, i));
    end
    // R4: idle cycle with ALU data wiggling keeps state
    @(negedge clk_i);
    alu_res_i = 8'h00; alu_cout_i = 1; alu_cmsb_i = 0; alu_acy_i = 1;
    @(negedge clk_i);
    check(8'h39, "R4 idle hold");
    idle();
    // R9: asynchronous reset, no clock edge in between
    @(negedge clk_i);
    rst_ni = 0;
    #1;
    check(8'h00, "R9 async reset");
    @(negedge clk_i);
    rst_ni = 1;
    // R5: halt and clear together, halt wins
    apply('{4'd5, 0,0, 8'h00, 0,0,0, 1,1,0, 0, 8'h00, 8'h10}, "R5 halt beats clear");
    apply('{4'd6, 0,0, 8'h00, 0,0,0, 0,0,1, 0, 8'h00, 8'h30}, "R6 timeout after reset");
    apply('{4'd7, 0,0, 8'h00, 0,0,0, 0,0,0, 1, 8'h0F, 8'h3F}, "R7 write keeps pd/to");
    apply('{4'd5, 0,0, 8'h00, 0,0,0, 1,0,0, 0, 8'h00, 8'h0F}, "R5 clear pd and to");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule